// File: doc/BRIEF.md
# SD Host Control Register with Self-Clearing Requests

This block is the control register of an SD/MMC host controller. It sits on a register bus in the system-clock domain: a single write strobe with 32 bits of write data, and a read-back word that always shows the live state of every bit. Three bits are plain settings that hold what software wrote: global interrupt enable, read-wait and CE-ATA device interrupt enable. The other bits are requests. Software writes a 1, the hardware carries out the action, and the bit returns to 0 on its own. Software can therefore poll a request bit until it reads 0.

The reset requests drive the controller, FIFO and DMA reset outputs. The controller and FIFO requests cross into the card-clock domain through two-flop synchronisers. Their card-side level is synchronised back as an acknowledgement, and each bit clears only when that acknowledgement has returned. After the FIFO request clears, the FIFO pointer reset is held for a short tail. The remaining requests are send-IRQ-response, abort-read-data, send-CCSD and send-auto-stop-CCSD. Each clears on a completion pulse from the command or data state machine. The two CCSD-related completions also raise the set strobes for the command-done and auto-command-done raw flags. The interrupt output combines the global enable with the masked raw flags.

Top module: `sdh_ctrl_reg`

## Requirements
- R1: After reset, every bit reads 0. In the read-back word, the bits that are not assigned (3, 5 and 12 upward) always read 0. Bit positions: 0 controller reset, 1 FIFO reset, 2 DMA reset, 4 interrupt enable, 6 read-wait, 7 send-IRQ-response, 8 abort-read-data, 9 send-CCSD, 10 send-auto-stop-CCSD, 11 CE-ATA interrupt enable.
- R2: A write of 1 to bit 2 raises `dma_rst` and bit 2. Both stay at 1 for exactly two system-clock cycles and then return to 0.
- R3: A write of 1 to bit 0 drives `card_ctl_rst` high after a two-flop card-clock synchroniser. Bit 0 stays at 1 until that level has returned through a two-flop system-clock synchroniser, and for at least two system cycles. While the returned acknowledgement is still high, a new write of 1 to bit 0 is ignored.
- R4: Bit 1 clears once its card-domain acknowledgement has returned. `fifo_ptr_rst` remains high for two further system cycles after bit 1 reads 0, then falls.
- R5: Bit 7 stays set until `cmd_irq_resp_done` is sampled high while bit 7 is set. It then reads 0 in the next cycle.
- R6: Bit 8 stays set until `data_abort_done` is sampled high while bit 8 is set. It then reads 0 in the next cycle.
- R7: Bit 9 clears on a `ccsd_sent` pulse. `cmd_done_set` is high in the same cycle as that pulse, and only while bit 9 is set. `card_ccsd_req` follows bit 9 into the card domain.
- R8: Bit 10 clears on an `auto_stop_done` pulse. `acd_set` is high in the same cycle as that pulse, and only while bit 10 is set.
- R9: `irq` is 1 exactly when bit 4 is 1 and at least one bit of `raw_flags & raw_mask` is 1.
- R10: While a request bit is pending, writing 0 to it has no effect. Writing 1 to it again does not restart its timing either.
- R11: Bits 4, 6 and 11 hold the last value written, both 0 and 1. Bit 6 drives `read_wait` and bit 11 drives `ceata_int_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| card_clk | input | 1 | Card clock |
| card_rst_n | input | 1 | Synchronous active-low reset, card domain |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Live read-back value |
| cmd_irq_resp_done | input | 1 | Command machine sent the interrupt response and is idle |
| data_abort_done | input | 1 | Data machine was forced back to idle |
| ccsd_sent | input | 1 | CCSD pattern has been sent |
| auto_stop_done | input | 1 | Internal stop command has completed |
| raw_flags | input | RAW_W | Raw interrupt flags |
| raw_mask | input | RAW_W | Interrupt mask, 1 = enabled |
| ctl_rst_req | output | 1 | Controller reset request, system domain |
| dma_rst | output | 1 | DMA interface reset |
| fifo_ptr_rst | output | 1 | FIFO pointer reset, system domain |
| card_ctl_rst | output | 1 | Controller reset, card domain |
| card_fifo_rst | output | 1 | FIFO reset, card domain |
| card_ccsd_req | output | 1 | Send-CCSD request, card domain |
| irq_resp_req | output | 1 | Send-IRQ-response request |
| abort_req | output | 1 | Abort-read-data request |
| ccsd_req | output | 1 | Send-CCSD request, system domain |
| auto_stop_req | output | 1 | Send-auto-stop request |
| read_wait | output | 1 | Read-wait setting |
| ceata_int_on | output | 1 | CE-ATA interrupt-enabled setting |
| cmd_done_set | output | 1 | Set strobe for the command-done raw flag |
| acd_set | output | 1 | Set strobe for the auto-command-done raw flag |
| irq | output | 1 | Interrupt output |

## Verification
The hardest situation to reach is the window just after the controller reset bit has cleared. At that point the acknowledgement is still high, so a new request must be refused. The bench polls bit 0 at every falling system edge and writes 1 again in the first cycle after it reads 0. The two clocks run at unrelated periods, so the clear lands at a varying phase. The FIFO pointer tail is checked the same way: the bench catches the exact cycle in which bit 1 first reads 0. The interrupt gating is swept over every combination of enable, flags and mask.

// File: rtl/sdh_ctrl_pkg.sv
// Package: bit positions of the control word shared by the register and its bench.
// Assumes a data width of at least 12 bits.
package sdh_ctrl_pkg;
    localparam int POS_CTL   = 0;
    localparam int POS_FIFO  = 1;
    localparam int POS_DMA   = 2;
    localparam int POS_INTEN = 4;
    localparam int POS_RWAIT = 6;
    localparam int POS_IRQR  = 7;
    localparam int POS_ABORT = 8;
    localparam int POS_CCSD  = 9;
    localparam int POS_ASTOP = 10;
    localparam int POS_CEATA = 11;
    localparam int NUM_EVT   = 4;
    // Event-completed request bits, in order of their done inputs.
    localparam int EVT_POS [NUM_EVT] = '{POS_IRQR, POS_ABORT, POS_CCSD, POS_ASTOP};
endpackage

// File: rtl/sdh_sync2.sv
// Two-flop synchroniser for W independent level signals.
// Assumes each input is a level held long enough to be sampled by clk.
module sdh_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two sampling stages in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sdh_selfclr_bit.sv
// One self-clearing request bit. A write of 1 sets it when it is idle and
// accept_ok is high. It clears once done is high and it has been set for at
// least MIN_SYS cycles. Writes while it is set are ignored.
module sdh_selfclr_bit #(
    parameter int MIN_SYS = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic accept_ok,
    input  logic done,
    output logic q,
    output logic clr
);
    logic elapsed;

    generate
        if (MIN_SYS >= 2) begin : g_cnt
            localparam int CW = $clog2(MIN_SYS + 1);
            localparam logic [CW-1:0] CMAX = CW'(MIN_SYS);
            logic [CW-1:0] cnt;
            // Count cycles since the bit was set, saturating.
            always_ff @(posedge clk) begin
                if (!rst_n || !q)    cnt <= '0;
                else if (cnt != CMAX) cnt <= cnt + 1'b1;
            end
            assign elapsed = (cnt >= CW'(MIN_SYS - 1));

            assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(q) |=> q);
        end else begin : g_nocnt
            assign elapsed = 1'b1;
        end
    endgenerate

    assign clr = q & elapsed & done;

    // Set on an accepted write, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                             q <= 1'b0;
        else if (q)                             q <= !clr;
        else if (wr_en && wr_bit && accept_ok)  q <= 1'b1;
    end

    assert_pending_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !done) |=> q);
endmodule

// File: rtl/sdh_ctrl_reg.sv
// Control register of an SD/MMC host with self-clearing request bits.
// The controller and FIFO requests cross into the card domain and are
// acknowledged back. The other requests clear on completion pulses.
// Assumes the done inputs are single-cycle pulses in the system domain.
module sdh_ctrl_reg
    import sdh_ctrl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RAW_W     = 8,
    parameter int DMA_CYC   = 2,
    parameter int CTL_MIN   = 2,
    parameter int FIFO_TAIL = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              card_clk,
    input  logic              card_rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmd_irq_resp_done,
    input  logic              data_abort_done,
    input  logic              ccsd_sent,
    input  logic              auto_stop_done,
    input  logic [RAW_W-1:0]  raw_flags,
    input  logic [RAW_W-1:0]  raw_mask,
    output logic              ctl_rst_req,
    output logic              dma_rst,
    output logic              fifo_ptr_rst,
    output logic              card_ctl_rst,
    output logic              card_fifo_rst,
    output logic              card_ccsd_req,
    output logic              irq_resp_req,
    output logic              abort_req,
    output logic              ccsd_req,
    output logic              auto_stop_req,
    output logic              read_wait,
    output logic              ceata_int_on,
    output logic              cmd_done_set,
    output logic              acd_set,
    output logic              irq
);
    localparam int TW = $clog2(FIFO_TAIL + 1);

    logic ctl_q, ctl_clr, fifo_q, fifo_clr, dma_q, dma_clr;
    logic int_en_q, rwait_q, ceata_q;
    logic ack_ctl, ack_fifo;
    logic [1:0] ack_sync;
    logic [2:0] card_side;
    logic [NUM_EVT-1:0] evt_done, evt_q, evt_clr;
    logic [TW-1:0] tail;

    // Controller reset: needs the card-domain acknowledgement and a minimum hold.
    sdh_selfclr_bit #(.MIN_SYS(CTL_MIN)) i_ctl (
        .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[POS_CTL]),
        .accept_ok(!ack_ctl), .done(ack_ctl), .q(ctl_q), .clr(ctl_clr));

    // FIFO reset: clears when the card domain acknowledges.
    sdh_selfclr_bit #(.MIN_SYS(0)) i_fifo (
        .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[POS_FIFO]),
        .accept_ok(!ack_fifo), .done(ack_fifo), .q(fifo_q), .clr(fifo_clr));

    // DMA reset: purely timed in the system domain.
    sdh_selfclr_bit #(.MIN_SYS(DMA_CYC)) i_dma (
        .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[POS_DMA]),
        .accept_ok(1'b1), .done(1'b1), .q(dma_q), .clr(dma_clr));

    assign evt_done = {auto_stop_done, ccsd_sent, data_abort_done, cmd_irq_resp_done};

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
            // Request bit cleared by its state-machine completion pulse.
            sdh_selfclr_bit #(.MIN_SYS(0)) i_evt (
                .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(reg_wr),
                .wr_bit(reg_wdata[EVT_POS[g]]), .accept_ok(1'b1),
                .done(evt_done[g]), .q(evt_q[g]), .clr(evt_clr[g]));
        end
    endgenerate

    // Plain setting bits hold what software writes.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            int_en_q <= 1'b0;
            rwait_q  <= 1'b0;
            ceata_q  <= 1'b0;
        end else if (reg_wr) begin
            int_en_q <= reg_wdata[POS_INTEN];
            rwait_q  <= reg_wdata[POS_RWAIT];
            ceata_q  <= reg_wdata[POS_CEATA];
        end
    end

    // Requests into the card domain.
    sdh_sync2 #(.W(3)) i_to_card (
        .clk(card_clk), .rst_n(card_rst_n),
        .d({evt_q[2], fifo_q, ctl_q}), .q(card_side));

    // Card-side levels back as acknowledgements.
    sdh_sync2 #(.W(2)) i_to_sys (
        .clk(sys_clk), .rst_n(sys_rst_n),
        .d(card_side[1:0]), .q(ack_sync));

    assign ack_ctl  = ack_sync[0];
    assign ack_fifo = ack_sync[1];

    // Hold the FIFO pointer reset for a tail after the request clears.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n)        tail <= '0;
        else if (fifo_clr)     tail <= TW'(FIFO_TAIL);
        else if (tail != '0)   tail <= tail - 1'b1;
    end

    // Read-back word assembled from live state.
    always_comb begin
        reg_rdata            = '0;
        reg_rdata[POS_CTL]   = ctl_q;
        reg_rdata[POS_FIFO]  = fifo_q;
        reg_rdata[POS_DMA]   = dma_q;
        reg_rdata[POS_INTEN] = int_en_q;
        reg_rdata[POS_RWAIT] = rwait_q;
        reg_rdata[POS_CEATA] = ceata_q;
        for (int k = 0; k < NUM_EVT; k++) reg_rdata[EVT_POS[k]] = evt_q[k];
    end

    assign ctl_rst_req   = ctl_q;
    assign dma_rst       = dma_q;
    assign fifo_ptr_rst  = fifo_q | (tail != '0);
    assign card_ctl_rst  = card_side[0];
    assign card_fifo_rst = card_side[1];
    assign card_ccsd_req = card_side[2];
    assign irq_resp_req  = evt_q[0];
    assign abort_req     = evt_q[1];
    assign ccsd_req      = evt_q[2];
    assign auto_stop_req = evt_q[3];
    assign read_wait     = rwait_q;
    assign ceata_int_on  = ceata_q;
    assign cmd_done_set  = evt_clr[2];
    assign acd_set       = evt_clr[3];
    assign irq           = int_en_q & (|(raw_flags & raw_mask));

    assert_ctl_ack_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $fell(ctl_q) |-> ack_ctl);
    assert_fifo_tail_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $fell(fifo_q) |-> (fifo_ptr_rst ##1 fifo_ptr_rst));
    assert_cmd_done_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cmd_done_set |=> !ccsd_req);
    assert_acd_R8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        acd_set |=> !auto_stop_req);
    assert_irq_gated_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        irq |-> (|(raw_flags & raw_mask)));
endmodule

// File: tb/test_sdh_ctrl_reg.sv
module test_sdh_ctrl_reg;
    localparam int SYS_PERIOD  = 10;
    localparam int CARD_PERIOD = 14;
    localparam int DW = 32;
    localparam int RW = 3;

    logic sys_clk = 0, card_clk = 0, sys_rst_n = 0, card_rst_n = 0;
    logic reg_wr = 0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic [3:0] dn = '0;
    logic [RW-1:0] raw_flags = '0, raw_mask = '0;
    logic ctl_rst_req, dma_rst, fifo_ptr_rst, card_ctl_rst, card_fifo_rst, card_ccsd_req;
    logic irq_resp_req, abort_req, ccsd_req, auto_stop_req, read_wait, ceata_int_on;
    logic cmd_done_set, acd_set, irq;
    int checks = 0, failures = 0;

    always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
    always #(CARD_PERIOD/2) card_clk = ~card_clk;

    sdh_ctrl_reg #(.DATA_W(DW), .RAW_W(RW)) i_sdh_ctrl_reg (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .card_clk(card_clk), .card_rst_n(card_rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_irq_resp_done(dn[0]), .data_abort_done(dn[1]), .ccsd_sent(dn[2]),
        .auto_stop_done(dn[3]), .raw_flags(raw_flags), .raw_mask(raw_mask),
        .ctl_rst_req(ctl_rst_req), .dma_rst(dma_rst), .fifo_ptr_rst(fifo_ptr_rst),
        .card_ctl_rst(card_ctl_rst), .card_fifo_rst(card_fifo_rst), .card_ccsd_req(card_ccsd_req),
        .irq_resp_req(irq_resp_req), .abort_req(abort_req), .ccsd_req(ccsd_req),
        .auto_stop_req(auto_stop_req), .read_wait(read_wait), .ceata_int_on(ceata_int_on),
        .cmd_done_set(cmd_done_set), .acd_set(acd_set), .irq(irq));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after it took effect.
    task automatic wr(input logic [DW-1:0] v);
        @(negedge sys_clk);
        reg_wr = 1; reg_wdata = v;
        @(negedge sys_clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    initial begin
        #(SYS_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pos [4] = '{7, 8, 9, 10};
        bit seen;
        int n;
        cyc(4);
        sys_rst_n = 1; card_rst_n = 1;
        @(negedge sys_clk);
        // R1: reset state
        chk(reg_rdata == 0, "R1 reset value", reg_rdata, 0);
        chk(irq == 0 && fifo_ptr_rst == 0, "R1 outputs idle", {irq, fifo_ptr_rst}, 0);

        // R1/R11: all ones reads only defined bits
        wr('1);
        chk(reg_rdata == 32'hFD7, "R1 defined bits only", reg_rdata, 32'hFD7);
        reg_wr = 0;
        wr('0);
        for (int i = 0; i < 4; i++) begin
            @(negedge sys_clk); dn[i] = 1; @(negedge sys_clk); dn[i] = 0;
        end
        cyc(30);
        chk(reg_rdata == 0, "R1 all requests cleared", reg_rdata, 0);

        // R11: plain bits both ways
        wr(32'h850);
        chk(reg_rdata == 32'h850 && read_wait && ceata_int_on, "R11 plain set",
            reg_rdata, 32'h850);
        wr(32'h040);
        chk(reg_rdata == 32'h040, "R11 plain partial", reg_rdata, 32'h040);
        wr(32'h0);
        chk(reg_rdata == 0 && !read_wait && !ceata_int_on, "R11 plain clear", reg_rdata, 0);

        // R2: DMA request high exactly two cycles
        wr(32'h4);
        chk(dma_rst && reg_rdata[2], "R2 dma cycle 1", dma_rst, 1);
        @(negedge sys_clk);
        chk(dma_rst && reg_rdata[2], "R2 dma cycle 2", dma_rst, 1);
        @(negedge sys_clk);
        chk(!dma_rst && !reg_rdata[2], "R2 dma cleared", dma_rst, 0);

        // R10: rewriting 1 while pending does not extend
        wr(32'h4);
        reg_wr = 1; reg_wdata = 32'h4;
        @(negedge sys_clk);
        reg_wr = 0; reg_wdata = 0;
        chk(dma_rst, "R10 dma still pending", dma_rst, 1);
        @(negedge sys_clk);
        chk(!dma_rst, "R10 rewrite did not restart", dma_rst, 0);

        // R3: controller reset handshake
        wr(32'h1);
        seen = 0; n = 0;
        while (!card_ctl_rst && n < 50) begin @(negedge sys_clk); n++; end
        chk(card_ctl_rst && ctl_rst_req, "R3 card sees request, bit still set",
            {card_ctl_rst, ctl_rst_req}, 3);
        n = 0;
        while (reg_rdata[0] && n < 50) begin @(negedge sys_clk); n++; end
        chk(!reg_rdata[0], "R3 bit cleared after ack", reg_rdata[0], 0);
        wr(32'h1);
        chk(!reg_rdata[0], "R3 rewrite during ack ignored", reg_rdata[0], 0);
        cyc(20);
        wr(32'h1);
        chk(reg_rdata[0], "R3 accepted once idle", reg_rdata[0], 1);
        cyc(30);

        // R4: FIFO reset and pointer tail
        wr(32'h2);
        chk(fifo_ptr_rst && reg_rdata[1], "R4 fifo set", fifo_ptr_rst, 1);
        n = 0;
        while (reg_rdata[1] && n < 50) begin @(negedge sys_clk); n++; end
        chk(card_fifo_rst && fifo_ptr_rst, "R4 tail 1, card side asserted",
            {card_fifo_rst, fifo_ptr_rst}, 3);
        @(negedge sys_clk);
        chk(fifo_ptr_rst, "R4 tail 2", fifo_ptr_rst, 1);
        @(negedge sys_clk);
        chk(!fifo_ptr_rst, "R4 tail ended", fifo_ptr_rst, 0);
        cyc(20);

        // R5..R8, R10: event-cleared requests
        for (int i = 0; i < 4; i++) begin
            // done while idle: no flag strobe, bit stays 0
            @(negedge sys_clk); dn[i] = 1; #1;
            chk(!cmd_done_set && !acd_set, "R7 R8 no strobe while idle",
                {cmd_done_set, acd_set}, 0);
            @(negedge sys_clk); dn[i] = 0;
            chk(reg_rdata[pos[i]] == 0, "R5 R6 done while idle ignored", reg_rdata, 0);
            wr(32'h1 << pos[i]);
            cyc(3);
            chk(reg_rdata[pos[i]], "R5 R6 R7 R8 held pending", reg_rdata, 32'h1 << pos[i]);
            if (i == 2) chk(card_ccsd_req, "R7 card ccsd request", card_ccsd_req, 1);
            wr(32'h0);
            chk(reg_rdata[pos[i]], "R10 write 0 ignored", reg_rdata, 32'h1 << pos[i]);
            dn[i] = 1; #1;
            chk(cmd_done_set == (i == 2), "R7 command-done strobe", cmd_done_set, i == 2);
            chk(acd_set == (i == 3), "R8 auto-done strobe", acd_set, i == 3);
            @(negedge sys_clk); dn[i] = 0;
            chk(reg_rdata == 0, "R5 R6 R7 R8 cleared on done", reg_rdata, 0);
        end

        // R9: exhaustive interrupt gating
        for (int e = 0; e < 2; e++) begin
            wr(e ? 32'h10 : 32'h0);
            for (int f = 0; f < (1 << RW); f++) begin
                for (int m = 0; m < (1 << RW); m++) begin
                    raw_flags = RW'(f); raw_mask = RW'(m); #1;
                    chk(irq == (e != 0 && (f & m) != 0), "R9 irq gating", irq,
                        (e != 0 && (f & m) != 0));
                end
            end
        end
        raw_flags = 0; raw_mask = 0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule